// File: doc/BRIEF.md
# Range-Selected Sensor Calibration Unit

This block corrects a pair of raw 16-bit converter readings, one of supply voltage and one of load current, before they enter a control loop. Each reading has an offset in raw counts subtracted from it, and the difference is scaled by an unsigned gain in 1.15 fixed point, so the gain is always below 2.0. The scaled result is rounded to the nearest whole count and returned as a 16-bit word. Negative differences clamp to zero and oversized results saturate at full scale.

Correction constants are not global. The voltage channel keeps eight constant pairs and picks one by the top three bits of its own raw reading. The current channel keeps sixteen pairs in two groups of eight. The most significant bit of the raw voltage picks the group, and the top three bits of the raw current pick the pair within it. Software loads every pair through a small write port at power-up. The loop sequencer then pulses a start strobe once per sample. Both channels work in parallel, and results appear with a done strobe a fixed three cycles later.

Top module: `sense_trim_unit`

## Requirements
- R1: For each channel, the output equals round((raw - offset) * gain / 2^15), where gain is an unsigned 16-bit 1.15 value and offset is in raw counts.
- R2: Rounding is to nearest, with an exact half rounded up: a difference of 1 with gain 0x4000 yields 1, and with gain 0x3FFF yields 0.
- R3: When raw is below the selected offset, the output is 0.
- R4: When the rounded result exceeds 0xFFFF, the output is 0xFFFF.
- R5: The voltage constant pair is selected by raw_v[15:13], giving eight equal-width ranges.
- R6: The current constant pair index is {raw_v[15], raw_i[15:13]}, giving two groups of eight pairs selected by the voltage half-range.
- R7: A write with cfg_we_i high stores cfg_data_i on the next clock. cfg_chan_i picks the bank (0 voltage, 1 current), cfg_gain_i picks the field (0 offset, 1 gain) and cfg_idx_i picks the pair. A voltage write with cfg_idx_i[3] set is ignored.
- R8: If start_i is high in cycle t, done_o is high in cycle t+3 and both outputs carry that sample's results. The outputs hold their value until the next done, and raw inputs presented without start_i have no effect.
- R9: After reset every offset is 0, every gain is 0x8000 (unity), both outputs are 0 and done_o is low.
- R10: A start may be given every cycle. Each start produces its own done and results three cycles later, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample strobe from the loop sequencer |
| raw_v_i | input | 16 | Raw voltage reading |
| raw_i_i | input | 16 | Raw current reading |
| cfg_we_i | input | 1 | Constant write enable |
| cfg_chan_i | input | 1 | Bank select: 0 voltage, 1 current |
| cfg_gain_i | input | 1 | Field select: 0 offset, 1 gain |
| cfg_idx_i | input | 4 | Constant pair index |
| cfg_data_i | input | 16 | Constant write data |
| cal_v_o | output | 16 | Calibrated voltage |
| cal_i_o | output | 16 | Calibrated current |
| done_o | output | 1 | Results valid strobe |

## Verification
The bench targets the rounding tie at half a count. A truncating design returns 0 there instead of 1. It drives raw readings just under an offset, where a design without the clamp wraps to a large value. It drives full-scale readings with near-2.0 gain, where a design without saturation drops the carry and emits a small number. It places current readings in the same range under both voltage halves, which exposes a design that ignores the group select or decodes the wrong bits. Writes to the unused voltage indices, and raw values that change between strobes, must leave the results untouched. Back-to-back strobes check that no sample's constants leak into its neighbour.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int TRIM_DATA_W = 16;
  localparam int TRIM_RANGE_BITS = 3;

  typedef enum logic {
    CH_VOLT = 1'b0,
    CH_CURR = 1'b1
  } trim_chan_e;
endpackage

// File: rtl/trim_bank.sv
module trim_bank #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_gain,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_gain
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [DATA_W-1:0] UNITY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DEPTH-1:0][DATA_W-1:0] off_all;
  logic [DEPTH-1:0][DATA_W-1:0] gain_all;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] off_q, gain_q;
    logic hit, off_en, gain_en;

    always_comb begin
      hit     = wr_en && (wr_idx == IDX_W'(e));
      off_en  = hit && !wr_gain;
      gain_en = hit && wr_gain;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q  <= '0;
        gain_q <= UNITY;
      end else begin
        if (off_en)  off_q  <= wr_data;
        if (gain_en) gain_q <= wr_data;
      end
    end

    assign off_all[e]  = off_q;
    assign gain_all[e] = gain_q;
  end

  assign rd_off  = off_all[rd_idx];
  assign rd_gain = gain_all[rd_idx];
endmodule

// File: rtl/trim_lane.sv
module trim_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_en,
  input  logic              s2_en,
  input  logic              s3_en,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] off,
  input  logic [DATA_W-1:0] gain,
  output logic [DATA_W-1:0] res
);
  localparam int FRAC_W = DATA_W - 1;
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = PROD_W + 1;
  localparam logic [EXT_W-1:0] HALF = {{(DATA_W+2){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              under;
  logic [DATA_W-1:0] diff_d, diff_q, gain_q;
  logic [PROD_W-1:0] prod_d, prod_q;
  logic [EXT_W-1:0]  rnd, shifted;
  logic [DATA_W-1:0] res_d, res_q;

  always_comb begin
    under  = raw < off;
    diff_d = under ? '0 : (raw - off);
    prod_d = diff_q * gain_q;
    rnd     = {1'b0, prod_q} + HALF;
    shifted = rnd >> FRAC_W;
    if (|shifted[EXT_W-1:DATA_W]) res_d = '1;
    else                          res_d = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= '0;
      gain_q <= '0;
      prod_q <= '0;
      res_q  <= '0;
    end else begin
      if (s1_en) begin
        diff_q <= diff_d;
        gain_q <= gain;
      end
      if (s2_en) prod_q <= prod_d;
      if (s3_en) res_q  <= res_d;
    end
  end

  assign res = res_q;

  logic [EXT_W-1:0] res_scaled, prod_ext;
  assign res_scaled = {2'b00, res_q, {FRAC_W{1'b0}}};
  assign prod_ext   = {1'b0, prod_q};

  AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_en && (raw < off)) |=> (diff_q == '0)); // R3

  AST_ROUND_NEAREST: assert property (@(posedge clk) disable iff (!rst_n)
    s3_en |=> ((&res_q) ||
               ((res_scaled <= $past(prod_ext) + HALF) &&
                ($past(prod_ext) + HALF < res_scaled + (HALF << 1))))); // R2
endmodule

// File: rtl/sense_trim_unit.sv
module sense_trim_unit #(
  parameter int DATA_W     = trim_pkg::TRIM_DATA_W,
  parameter int RANGE_BITS = trim_pkg::TRIM_RANGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] raw_v_i,
  input  logic [DATA_W-1:0] raw_i_i,
  input  logic              cfg_we_i,
  input  logic              cfg_chan_i,
  input  logic              cfg_gain_i,
  input  logic [RANGE_BITS:0] cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic [DATA_W-1:0] cal_v_o,
  output logic [DATA_W-1:0] cal_i_o,
  output logic              done_o
);
  import trim_pkg::*;

  localparam int V_IDX_W = RANGE_BITS;
  localparam int I_IDX_W = RANGE_BITS + 1;

  logic [V_IDX_W-1:0] v_sel;
  logic [I_IDX_W-1:0] i_sel;
  logic               v_we, i_we;
  logic [DATA_W-1:0]  v_off, v_gain, i_off, i_gain;
  logic vld1_d, vld1_q, vld2_d, vld2_q, done_d, done_q;

  always_comb begin
    v_sel = raw_v_i[DATA_W-1 -: RANGE_BITS];
    i_sel = {raw_v_i[DATA_W-1], raw_i_i[DATA_W-1 -: RANGE_BITS]};
    v_we  = cfg_we_i && (trim_chan_e'(cfg_chan_i) == CH_VOLT) && !cfg_idx_i[RANGE_BITS];
    i_we  = cfg_we_i && (trim_chan_e'(cfg_chan_i) == CH_CURR);
  end

  trim_bank #(.DATA_W(DATA_W), .IDX_W(V_IDX_W)) u_vbank (
    .clk(clk), .rst_n(rst_n), .wr_en(v_we), .wr_gain(cfg_gain_i),
    .wr_idx(cfg_idx_i[V_IDX_W-1:0]), .wr_data(cfg_data_i),
    .rd_idx(v_sel), .rd_off(v_off), .rd_gain(v_gain)
  );

  trim_bank #(.DATA_W(DATA_W), .IDX_W(I_IDX_W)) u_ibank (
    .clk(clk), .rst_n(rst_n), .wr_en(i_we), .wr_gain(cfg_gain_i),
    .wr_idx(cfg_idx_i), .wr_data(cfg_data_i),
    .rd_idx(i_sel), .rd_off(i_off), .rd_gain(i_gain)
  );

  trim_lane #(.DATA_W(DATA_W)) u_vlane (
    .clk(clk), .rst_n(rst_n), .s1_en(start_i), .s2_en(vld1_q), .s3_en(vld2_q),
    .raw(raw_v_i), .off(v_off), .gain(v_gain), .res(cal_v_o)
  );

  trim_lane #(.DATA_W(DATA_W)) u_ilane (
    .clk(clk), .rst_n(rst_n), .s1_en(start_i), .s2_en(vld1_q), .s3_en(vld2_q),
    .raw(raw_i_i), .off(i_off), .gain(i_gain), .res(cal_i_o)
  );

  always_comb begin
    vld1_d = start_i;
    vld2_d = vld1_q;
    done_d = vld2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1_q <= 1'b0;
      vld2_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld1_q <= vld1_d;
      vld2_q <= vld2_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##3 done_o); // R8

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !vld2_q |=> ($stable(cal_v_o) && $stable(cal_i_o))); // R8
endmodule

// File: tb/test_sense_trim_unit.sv
module test_sense_trim_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] raw_v, raw_i;
  logic        cfg_we, cfg_chan, cfg_gain;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_data;
  logic [15:0] cal_v, cal_i;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  logic [15:0] m_voff [8];
  logic [15:0] m_vgain[8];
  logic [15:0] m_ioff [16];
  logic [15:0] m_igain[16];

  always #4 clk = ~clk;

  sense_trim_unit i_sense_trim_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .raw_v_i(raw_v), .raw_i_i(raw_i),
    .cfg_we_i(cfg_we), .cfg_chan_i(cfg_chan), .cfg_gain_i(cfg_gain),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .cal_v_o(cal_v), .cal_i_o(cal_i), .done_o(done)
  );

  function automatic logic [15:0] exp_cal(input logic [15:0] raw, off, gain);
    logic [32:0] p;
    logic [32:0] r;
    if (raw < off) return 16'h0000;
    p = 33'(raw - off) * 33'(gain) + 33'd16384;
    r = p >> 15;
    if (r > 33'd65535) return 16'hFFFF;
    return r[15:0];
  endfunction

  function automatic logic [15:0] exp_v(input logic [15:0] rv);
    return exp_cal(rv, m_voff[rv[15:13]], m_vgain[rv[15:13]]);
  endfunction

  function automatic logic [15:0] exp_i(input logic [15:0] rv, ri);
    return exp_cal(ri, m_ioff[{rv[15], ri[15:13]}], m_igain[{rv[15], ri[15:13]}]);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic ch, input logic g, input logic [3:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_chan = ch; cfg_gain = g; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    if (ch == 1'b0) begin
      if (!idx[3]) begin
        if (g) m_vgain[idx[2:0]] = d; else m_voff[idx[2:0]] = d;
      end
    end else begin
      if (g) m_igain[idx] = d; else m_ioff[idx] = d;
    end
  endtask

  task automatic run(input logic [15:0] rv, ri, input string req);
    logic [15:0] ev, ei;
    ev = exp_v(rv);
    ei = exp_i(rv, ri);
    @(negedge clk);
    start = 1; raw_v = rv; raw_i = ri;
    @(negedge clk);
    start = 0; raw_v = 16'($urandom); raw_i = 16'($urandom);
    chk("R8 done early", {15'd0, done}, 16'd0);
    @(negedge clk);
    raw_v = 16'($urandom); raw_i = 16'($urandom);
    chk("R8 done early", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk("R8 done at t+3", {15'd0, done}, 16'd1);
    chk({req, " voltage"}, cal_v, ev);
    chk({req, " current"}, cal_i, ei);
    @(negedge clk);
    chk("R8 done single", {15'd0, done}, 16'd0);
    chk("R8 hold voltage", cal_v, ev);
    chk("R8 hold current", cal_i, ei);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [15:0] bv[8], bi[8], ev[8], ei[8];
    void'($urandom(32'd4242));
    for (int k = 0; k < 8; k++) begin m_voff[k] = 0; m_vgain[k] = 16'h8000; end
    for (int k = 0; k < 16; k++) begin m_ioff[k] = 0; m_igain[k] = 16'h8000; end
    rst_n = 0; start = 0; raw_v = 0; raw_i = 0;
    cfg_we = 0; cfg_chan = 0; cfg_gain = 0; cfg_idx = 0; cfg_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset done", {15'd0, done}, 16'd0);
    chk("R9 reset voltage", cal_v, 16'd0);
    chk("R9 reset current", cal_i, 16'd0);

    // R9: unity constants after reset pass raw through
    run(16'h1234, 16'hABCD, "R9 unity defaults");
    chk("R9 identity voltage", cal_v, 16'h1234);
    chk("R9 identity current", cal_i, 16'hABCD);

    // R2: tie rounds up, below half rounds down
    wr(0, 1, 4'd0, 16'h4000);
    run(16'h0001, 16'h0001, "R2 tie");
    chk("R2 tie value", cal_v, 16'h0001);
    wr(0, 1, 4'd0, 16'h3FFF);
    run(16'h0001, 16'h0001, "R2 below half");
    chk("R2 below half value", cal_v, 16'h0000);

    // R3: raw below offset clamps to zero
    wr(0, 0, 4'd2, 16'h5000);
    run(16'h4800, 16'h0100, "R3 clamp");
    chk("R3 clamp value", cal_v, 16'h0000);
    run(16'h5000, 16'h0100, "R3 at offset");

    // R4: saturation at full scale
    wr(0, 1, 4'd7, 16'hFFFF);
    wr(1, 1, 4'd15, 16'hFFFF);
    run(16'hFFFF, 16'hFFFF, "R4 saturate");
    chk("R4 saturate voltage", cal_v, 16'hFFFF);
    chk("R4 saturate current", cal_i, 16'hFFFF);

    // R5: each voltage range uses its own pair
    for (int k = 0; k < 8; k++) wr(0, 0, 4'(k), 16'(k * 16'h0111));
    for (int k = 0; k < 8; k++) run({3'(k), 13'h0ABC}, 16'h0000, "R5 voltage range");

    // R6: voltage half-range picks the current group
    wr(1, 0, 4'd3, 16'h0010);
    wr(1, 0, 4'd11, 16'h0200);
    wr(1, 1, 4'd11, 16'h6000);
    run(16'h1000, 16'h6400, "R6 low group");
    run(16'h9000, 16'h6400, "R6 high group");
    chk("R6 group differ", {15'd0, cal_i == exp_cal(16'h6400, 16'h0010, 16'h8000)}, 16'd0);

    // R7: voltage write with idx[3] set is ignored
    wr(0, 0, 4'd0, 16'h0000);
    wr(0, 1, 4'd0, 16'h8000);
    wr(0, 0, 4'b1000, 16'h0777);
    wr(0, 1, 4'b1000, 16'h2000);
    run(16'h1000, 16'h0000, "R7 ignored write");
    chk("R7 ignored value", cal_v, 16'h1000);

    // R1: random constants and readings
    for (int k = 0; k < 8; k++) begin
      wr(0, 0, 4'(k), 16'($urandom_range(0, 16'h2000)));
      wr(0, 1, 4'(k), 16'($urandom));
    end
    for (int k = 0; k < 16; k++) begin
      wr(1, 0, 4'(k), 16'($urandom_range(0, 16'h2000)));
      wr(1, 1, 4'(k), 16'($urandom));
    end
    for (int n = 0; n < 200; n++) run(16'($urandom), 16'($urandom), "R1 random");

    // R10: back-to-back starts
    for (int k = 0; k < 8; k++) begin
      bv[k] = 16'($urandom); bi[k] = 16'($urandom);
      ev[k] = exp_v(bv[k]); ei[k] = exp_i(bv[k], bi[k]);
    end
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        chk("R10 done stream", {15'd0, done}, 16'd1);
        chk("R10 voltage stream", cal_v, ev[c-3]);
        chk("R10 current stream", cal_i, ei[c-3]);
      end
      if (c < 8) begin start = 1; raw_v = bv[c]; raw_i = bi[c]; end
      else start = 0;
    end
    @(negedge clk);
    chk("R10 stream end", {15'd0, done}, 16'd0);
    finish_up();
  end
endmodule